// File: doc/BRIEF.md
# Command-Driven I2C Master Engine

This block is a single-master I2C bus engine. Each accepted request carries out exactly one bus primitive. The primitive is chosen by one-hot bits of an 8-bit command byte:

- start (or repeated start) followed by an address byte,
- write a byte,
- read a byte,
- stop,
- null.

The block drives SCL as a plain output. It controls SDA as an open-drain line through a pull-low enable. It reports the acknowledge seen on the ninth clock of a transmitted byte and the byte received by a read. It pulses a done flag when the primitive is complete.

A host sequences whole transactions by issuing primitives one after another. For example, start with the address, then one or more writes or reads, then stop. Between primitives the engine holds the bus with SCL low.

Each SCL period is split into four equal quarters. SDA therefore only moves in the middle of a low phase, and data is sampled in the middle of a high phase. The quarter length is derived from a system-clock parameter and a 2-bit rate select. The rate select picks 100, 200, 300 or 400 kHz.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, and after any stop, the bus is free. In that state `scl_o` is 1, `sda_oe_o` is 0 and `busy_o` is 0.
- R2: With the bus free, a command with bit 7 set generates a start: SDA falls while SCL is high. With the bus held, SDA is first released while SCL is low, then SCL is raised, and then the start follows (repeated start). In both cases `data_i` is then sent MSB first, followed by a ninth clock.
- R3: With the bus held, a command whose highest set bit is bit 6 transmits `data_i` MSB first, followed by a ninth clock. SDA is released during that ninth clock.
- R4: With the bus held, a command whose highest set bit is bit 5 reads one byte MSB first into `rdata_o`, and `data_i` has no effect on the bus. On the ninth clock the engine drives SDA low (ACK) if command bit 0 is 0, and releases SDA (NACK) if command bit 0 is 1.
- R5: After a start or write, `ack_o` is 1 if SDA was low on the ninth clock and 0 otherwise. Read and null commands leave `ack_o` unchanged.
- R6: With the bus held, a command whose highest set bit is bit 4 generates a stop: SDA rises while SCL is high, and the bus becomes free.
- R7: Priority among the command bits is 7 > 6 > 5 > 4. A command with none of bits 7..4 set is null: it has no bus effect, and `done_o` pulses in the cycle after the request.
- R8: A write, read or stop issued while the bus is free causes no bus activity, and `done_o` pulses in the cycle after the request.
- R9: SDA is only pulled low or released, and `sda_oe_o` never changes in a cycle where `scl_o` changes.
- R10: `rate_i` values 0, 1, 2 and 3 select 100, 200, 300 and 400 kHz. One quarter lasts CLK_HZ/(4·f) clock cycles. `busy_o` stays high for:
  - 39 quarters for a start from a free bus,
  - 40 quarters for a repeated start,
  - 36 quarters for a write or a read,
  - 3 quarters for a stop.
- R11: `done_o` is a one-cycle pulse when a primitive ends, and `busy_o` is low in that cycle. A request that arrives while `busy_o` is high is ignored.
- R12: A null command while the bus is held leaves SCL low and keeps the bus held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle |
| cmd_i | input | 8 | One-hot command byte |
| data_i | input | BYTE_W | Address or write data |
| rate_i | input | 2 | SCL rate select (0 = 100 kHz ... 3 = 400 kHz) |
| busy_o | output | 1 | Primitive in progress |
| done_o | output | 1 | Primitive finished (pulse) |
| ack_o | output | 1 | Last transmitted byte was acknowledged |
| rdata_o | output | BYTE_W | Last received byte |
| scl_o | output | 1 | SCL level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
If the sequencer phase or the bit counter is wrong, the effect shows at the ports within one quarter. It appears as an SDA edge while SCL is high that a bus monitor decodes as a spurious start or stop. It can also appear as a byte that ends a bit early or late, which the monitor reports as a wrong value or acknowledge on the next ninth clock.

A shift register that does not shift correctly shows up at the first wrongly ordered bit of the byte. A wrong quarter length appears as a wrong busy duration at the end of the primitive. A wrong held/free decision appears as bus activity on a command that should be a no-op, or as a missing repeated start.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  localparam int unsigned RATE_STEP_HZ = 100_000;
  localparam int unsigned RATE_N       = 4;

  localparam int unsigned CMD_START_B = 7;
  localparam int unsigned CMD_WRITE_B = 6;
  localparam int unsigned CMD_READ_B  = 5;
  localparam int unsigned CMD_STOP_B  = 4;
  localparam int unsigned CMD_NACK_B  = 0;

  typedef enum logic [2:0] {
    OP_NULL, OP_START, OP_WRITE, OP_READ, OP_STOP
  } op_e;

  typedef enum logic [3:0] {
    ST_FREE, ST_HOLD, ST_RS_PREP, ST_START_A, ST_START_B, ST_START_C,
    ST_BIT, ST_STOP_A, ST_STOP_B, ST_STOP_C
  } st_e;

  // quarter length in clock cycles for rate index sel (sel+1)*100 kHz
  function automatic int unsigned quarter_len(int unsigned clk_hz, int unsigned sel);
    int unsigned q;
    q = clk_hz / (4 * (sel + 1) * RATE_STEP_HZ);
    return (q == 0) ? 1 : q;
  endfunction

endpackage

// File: rtl/i2c_qtr_timer.sv
module i2c_qtr_timer
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned CLK_HZ = 4_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  localparam int unsigned QMAX = quarter_len(CLK_HZ, 0);
  localparam int unsigned CW   = $clog2(QMAX + 1);

  logic [CW-1:0] qlen_tab [RATE_N];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] qlen_m1;

  for (genvar g = 0; g < RATE_N; g++) begin : g_rate
    localparam int unsigned QL = quarter_len(CLK_HZ, g);
    assign qlen_tab[g] = CW'(QL);
  end

  assign qlen_m1 = qlen_tab[rate_i] - CW'(1);
  assign tick_o  = run_i && (cnt_q == qlen_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
  import i2c_cmd_pkg::*;
(
  input  logic [7:0] cmd_i,
  output op_e        op_o,
  output logic       nack_o
);
  logic unused_cmd;
  assign unused_cmd = ^cmd_i[3:1];

  always_comb begin
    if      (cmd_i[CMD_START_B]) op_o = OP_START;
    else if (cmd_i[CMD_WRITE_B]) op_o = OP_WRITE;
    else if (cmd_i[CMD_READ_B])  op_o = OP_READ;
    else if (cmd_i[CMD_STOP_B])  op_o = OP_STOP;
    else                         op_o = OP_NULL;
  end

  assign nack_o = cmd_i[CMD_NACK_B];
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         shift_i,
  input  logic         sin_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= din_i;
    else if (shift_i) q_o <= {q_o[W-2:0], sin_i};
  end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned CLK_HZ = 4_000_000,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [7:0]        cmd_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [1:0]        rate_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ack_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              scl_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  localparam int unsigned BCW = $clog2(BYTE_W + 1);
  localparam logic [BCW-1:0] ACK_SLOT = BCW'(BYTE_W);

  st_e             st_q;
  op_e             op;
  logic            cmd_nack;
  logic            held, accept, tick;
  logic [1:0]      qph_q;
  logic [BCW-1:0]  bcnt_q;
  logic            is_read_q, nack_q;
  logic            scl_q, sda_low_q, ack_q, done_q;
  logic [BYTE_W-1:0] rdata_q, sh_q;
  logic            sh_shift, bit_low;

  assign held   = (st_q == ST_HOLD);
  assign busy_o = (st_q != ST_FREE) && (st_q != ST_HOLD);
  assign accept = req_i && !busy_o;

  i2c_cmd_decode i_dec (
    .cmd_i  (cmd_i),
    .op_o   (op),
    .nack_o (cmd_nack)
  );

  i2c_qtr_timer #(.CLK_HZ(CLK_HZ)) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .rate_i (rate_i),
    .tick_o (tick)
  );

  // sample in mid-high quarter of the data bits
  assign sh_shift = tick && (st_q == ST_BIT) && (qph_q == 2'd2) && (bcnt_q != ACK_SLOT);

  i2c_byte_shift #(.W(BYTE_W)) i_sh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .din_i   (data_i),
    .shift_i (sh_shift),
    .sin_i   (sda_i),
    .q_o     (sh_q)
  );

  // level driven for the current bit: data bits vs acknowledge slot
  always_comb begin
    if (bcnt_q != ACK_SLOT) bit_low = is_read_q ? 1'b0 : !sh_q[BYTE_W-1];
    else                    bit_low = is_read_q ? !nack_q : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_FREE;
      qph_q     <= '0;
      bcnt_q    <= '0;
      is_read_q <= 1'b0;
      nack_q    <= 1'b0;
      scl_q     <= 1'b1;
      sda_low_q <= 1'b0;
      ack_q     <= 1'b0;
      done_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_FREE, ST_HOLD: begin
          if (accept) begin
            unique case (op)
              OP_START: begin
                is_read_q <= 1'b0;
                sda_low_q <= 1'b0;
                st_q      <= held ? ST_RS_PREP : ST_START_A;
              end
              OP_WRITE, OP_READ: begin
                if (held) begin
                  is_read_q <= (op == OP_READ);
                  nack_q    <= cmd_nack;
                  qph_q     <= '0;
                  bcnt_q    <= '0;
                  st_q      <= ST_BIT;
                end else begin
                  done_q <= 1'b1;
                end
              end
              OP_STOP: begin
                if (held) st_q <= ST_STOP_A;
                else      done_q <= 1'b1;
              end
              default: done_q <= 1'b1;
            endcase
          end
        end
        ST_RS_PREP: if (tick) begin scl_q <= 1'b1; st_q <= ST_START_A; end
        ST_START_A: if (tick) begin sda_low_q <= 1'b1; st_q <= ST_START_B; end
        ST_START_B: if (tick) begin scl_q <= 1'b0; st_q <= ST_START_C; end
        ST_START_C: if (tick) begin qph_q <= '0; bcnt_q <= '0; st_q <= ST_BIT; end
        ST_BIT: if (tick) begin
          unique case (qph_q)
            2'd0: sda_low_q <= bit_low;
            2'd1: scl_q <= 1'b1;
            2'd2: if (bcnt_q == ACK_SLOT && !is_read_q) ack_q <= !sda_i;
            default: begin
              scl_q <= 1'b0;
              if (bcnt_q == ACK_SLOT) begin
                st_q   <= ST_HOLD;
                done_q <= 1'b1;
                if (is_read_q) rdata_q <= sh_q;
              end else begin
                bcnt_q <= bcnt_q + BCW'(1);
              end
            end
          endcase
          qph_q <= qph_q + 2'd1;
        end
        ST_STOP_A: if (tick) begin sda_low_q <= 1'b1; st_q <= ST_STOP_B; end
        ST_STOP_B: if (tick) begin scl_q <= 1'b1; st_q <= ST_STOP_C; end
        ST_STOP_C: if (tick) begin
          sda_low_q <= 1'b0;
          st_q      <= ST_FREE;
          done_q    <= 1'b1;
        end
        default: st_q <= ST_FREE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign ack_o    = ack_q;
  assign rdata_o  = rdata_q;
  assign scl_o    = scl_q;
  assign sda_oe_o = sda_low_q;
endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic scl_o,
  input logic sda_oe_o,
  input logic held
);
  AST_FREE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !held) |-> (scl_o && !sda_oe_o)); // R1

  AST_HELD_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held |-> !scl_o); // R12

  AST_SDA_STILL_ON_SCL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_o) |-> $stable(sda_oe_o)); // R9

  AST_START_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && $rose(sda_oe_o)) |-> busy_o); // R2

  AST_STOP_ENDS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && $fell(sda_oe_o)) |-> (done_o && !held)); // R6

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R11

  AST_BUSY_END_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R11
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .scl_o    (scl_o),
  .sda_oe_o (sda_oe_o),
  .held     (held)
);

// File: tb/test_i2c_cmd_engine.sv
`timescale 1ns/1ps
module test_i2c_cmd_engine;
  localparam int unsigned CLK_HZ = 4_000_000;
  localparam logic [6:0]  SLV    = 7'h50;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [7:0] cmd_i = '0;
  logic [7:0] data_i = '0;
  logic [1:0] rate_i = '0;
  logic       busy_o, done_o, ack_o, scl_o, sda_oe_o;
  logic [7:0] rdata_o;
  logic       slave_low = 1'b0;
  logic       sda_line;

  assign sda_line = !sda_oe_o && !slave_low;  // pull-up model

  always #2 clk_i = !clk_i;

  i2c_cmd_engine #(.CLK_HZ(CLK_HZ)) i_i2c_cmd_engine (
    .clk_i, .rst_ni, .req_i, .cmd_i, .data_i, .rate_i,
    .busy_o, .done_o, .ack_o, .rdata_o, .scl_o, .sda_oe_o,
    .sda_i (sda_line)
  );

  typedef struct packed { logic [1:0] kind; logic [7:0] val; logic line; } ev_t;
  localparam logic [1:0] EV_START = 2'd0, EV_STOP = 2'd1, EV_BYTE = 2'd2;

  ev_t exp_q[$];
  int  n_chk = 0, n_bad = 0;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic ev_t mk(logic [1:0] k, logic [7:0] v, logic l);
    ev_t e; e.kind = k; e.val = v; e.line = l; return e;
  endfunction

  task automatic got(ev_t a);
    ev_t e;
    if (exp_q.size() == 0) chk(0, "R2", "unexpected bus event", int'(a), 0);
    else begin
      e = exp_q.pop_front();
      chk(a == e, (e.kind == EV_STOP) ? "R6" : "R3", "bus event {kind,byte,ack-line}", int'(a), int'(e));
    end
  endtask

  // bus monitor + slave model
  logic       p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] s_sh = '0;
  int         s_bc = 0, s_txn = 0;
  bit         s_first = 0, s_read = 0, s_match = 0;

  always @(negedge clk_i) begin
    if (scl_o && p_scl && p_sda && !sda_line) begin
      got(mk(EV_START, 8'h00, 1'b0));
      s_bc = 0; s_first = 1; s_read = 0; s_txn = 0; slave_low = 1'b0;
    end else if (scl_o && p_scl && !p_sda && sda_line) begin
      got(mk(EV_STOP, 8'h00, 1'b0));
      s_read = 0; slave_low = 1'b0;
    end else if (scl_o && !p_scl) begin
      if (s_bc < 8) begin
        s_sh = {s_sh[6:0], sda_line}; s_bc++;
      end else begin
        got(mk(EV_BYTE, s_sh, sda_line));
        if (s_first) begin
          s_match = (s_sh[7:1] == SLV);
          s_read  = s_match && s_sh[0];
          s_first = 0;
        end else if (s_read) begin
          s_txn++;
          if (sda_line) s_read = 0;
        end
        s_bc = 0;
      end
    end else if (!scl_o && p_scl) begin
      if (s_bc == 8) begin
        if (s_first)      slave_low = (s_sh[7:1] == SLV);
        else if (!s_read) slave_low = s_match && (s_sh != 8'hFF);
        else              slave_low = 1'b0;
      end else if (s_read && !s_first) begin
        slave_low = !((s_txn == 0) ? 8'hA5 : 8'h3C) >> 0 == 0 ? 1'b0 : 1'b0;
        slave_low = !(((s_txn == 0) ? 8'hA5 : 8'h3C) >> (7 - s_bc) & 8'h01);
      end else begin
        slave_low = 1'b0;
      end
    end
    p_scl = scl_o;
    p_sda = sda_line;
  end

  task automatic issue(logic [7:0] c, logic [7:0] d);
    @(negedge clk_i);
    cmd_i = c; data_i = d; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_done(output int bc);
    bc = 0;
    while (!done_o) begin
      if (busy_o) bc++;
      @(negedge clk_i);
    end
  endtask

  int bc;

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(0, "R11", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(scl_o && !sda_oe_o && !busy_o && !done_o, "R1", "reset state", {scl_o, sda_oe_o, busy_o, done_o}, 4'b1000);

    // R2 start from free bus, address write, rate 100 kHz
    rate_i = 2'd0;
    exp_q.push_back(mk(EV_START, 0, 0)); exp_q.push_back(mk(EV_BYTE, 8'hA0, 1'b0));
    issue(8'h80, 8'hA0); wait_done(bc);
    chk(ack_o == 1'b1, "R2", "address ack", ack_o, 1);
    chk(bc == 390, "R10", "start busy cycles 100k", bc, 390);

    // R3 write at 400 kHz
    rate_i = 2'd3;
    exp_q.push_back(mk(EV_BYTE, 8'h5A, 1'b0));
    issue(8'h40, 8'h5A); wait_done(bc);
    chk(ack_o == 1'b1, "R3", "write ack", ack_o, 1);
    chk(bc == 72, "R10", "write busy cycles 400k", bc, 72);

    // R5 NACKed byte at 200 kHz
    rate_i = 2'd1;
    exp_q.push_back(mk(EV_BYTE, 8'hFF, 1'b1));
    issue(8'h40, 8'hFF); wait_done(bc);
    chk(ack_o == 1'b0, "R5", "nack reported", ack_o, 0);
    chk(bc == 180, "R10", "write busy cycles 200k", bc, 180);

    // R12 null while held
    issue(8'h00, 8'h77);
    chk(done_o == 1'b1, "R12", "null done next cycle", done_o, 1);
    repeat (20) @(negedge clk_i);
    chk(!scl_o && !busy_o, "R12", "bus still held after null", {scl_o, busy_o}, 0);

    // R11 request while busy is ignored, 300 kHz
    rate_i = 2'd2;
    exp_q.push_back(mk(EV_BYTE, 8'h33, 1'b0));
    issue(8'h40, 8'h33);
    repeat (10) @(negedge clk_i);
    issue(8'h10, 8'h00);
    wait_done(bc);
    repeat (30) @(negedge clk_i);
    chk(!scl_o && !busy_o, "R11", "stop during busy ignored", {scl_o, busy_o}, 0);

    // R2 repeated start with read address
    rate_i = 2'd0;
    exp_q.push_back(mk(EV_START, 0, 0)); exp_q.push_back(mk(EV_BYTE, 8'hA1, 1'b0));
    issue(8'h80, 8'hA1); wait_done(bc);
    chk(bc == 400, "R10", "repeated start busy cycles", bc, 400);
    chk(ack_o == 1'b1, "R2", "read address ack", ack_o, 1);

    // R4 read with ACK, data_i all zero must not disturb the bus
    exp_q.push_back(mk(EV_BYTE, 8'hA5, 1'b0));
    issue(8'h20, 8'h00); wait_done(bc);
    chk(rdata_o == 8'hA5, "R4", "first read byte", rdata_o, 8'hA5);
    chk(ack_o == 1'b1, "R5", "ack unchanged by read", ack_o, 1);

    // R4 read with NACK (bit 0)
    exp_q.push_back(mk(EV_BYTE, 8'h3C, 1'b1));
    issue(8'h21, 8'h00); wait_done(bc);
    chk(rdata_o == 8'h3C, "R4", "second read byte", rdata_o, 8'h3C);

    // R6 stop
    exp_q.push_back(mk(EV_STOP, 0, 0));
    issue(8'h10, 8'h00); wait_done(bc);
    chk(bc == 30, "R10", "stop busy cycles", bc, 30);
    @(negedge clk_i);
    chk(scl_o && !sda_oe_o && !busy_o, "R6", "bus free after stop", {scl_o, sda_oe_o, busy_o}, 3'b100);

    // R8 write and read on free bus do nothing
    issue(8'h40, 8'h12);
    chk(done_o && !busy_o, "R8", "write on free bus done at once", {done_o, busy_o}, 2'b10);
    issue(8'h20, 8'h00);
    chk(done_o && !busy_o, "R8", "read on free bus done at once", {done_o, busy_o}, 2'b10);
    repeat (20) @(negedge clk_i);
    chk(scl_o && !sda_oe_o, "R8", "bus untouched", {scl_o, sda_oe_o}, 2'b10);

    // R7 null on free bus
    issue(8'h0E, 8'hFF);
    chk(done_o && !busy_o, "R7", "null done next cycle", {done_o, busy_o}, 2'b10);

    // R7 priority: bits 7 and 6 set acts as start; wrong address NACK
    exp_q.push_back(mk(EV_START, 0, 0)); exp_q.push_back(mk(EV_BYTE, 8'h84, 1'b1));
    issue(8'hC0, 8'h84); wait_done(bc);
    chk(ack_o == 1'b0, "R7", "start wins priority, nack", ack_o, 0);
    chk(bc == 390, "R7", "start-length busy", bc, 390);

    // R7 stop with a low-order bit set
    exp_q.push_back(mk(EV_STOP, 0, 0));
    issue(8'h18, 8'h00); wait_done(bc);
    repeat (5) @(negedge clk_i);
    chk(scl_o && !sda_oe_o, "R1", "free after final stop", {scl_o, sda_oe_o}, 2'b10);

    chk(exp_q.size() == 0, "R2", "expected bus events left", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule